// File: doc/BRIEF.md
# Cadence Gate Controller

This block switches a signal generator on and off in a repeating cadence. Each channel has an on interval and an off interval, both counted in sample-rate ticks. While the channel's oscillator enable is high, the channel's gate output alternates between the two intervals. Each interval is timed by its own timer, and each timer has its own enable bit. A disabled timer holds its phase for as long as the enable stays high, so the same two timers also decide when the gated state is entered and when it is left.

The end of every interval is an event that can be reported. The on→off event and the off→on event of each channel each have their own mask bit. A pending flag for an event is latched only when its mask bit is set, and software clears it by writing 1 to it. One interrupt line combines all pending flags. Two tone channels use the default of two channels; one channel is enough for ringing.

Software reaches the block through a simple register port. Writes take effect on the next clock edge. The read data follows the read address combinationally.

Top module: `cadence_gate_ctrl`

## Requirements
- R1: After reset, every gate output and `irq` are 0, and every register, including the status register, reads 0.
- R2: While `osc_en[c]` is 0, `gate[c]` is 0. In the first cycle that `osc_en[c]` is 1 after being 0, `gate[c]` is 1, because the channel always starts in the on phase.
- R3: In the on phase with the on-timer enabled and on-duration D, the phase lasts max(D,1) ticks. After the clock edge at which the last tick is sampled, `gate[c]` is 0. Cycles with `tick` low do not advance the count. The maximum duration 64000 (8 s of 8 kHz ticks) is honoured.
- R4: In the off phase with the off-timer enabled and off-duration D, the phase lasts max(D,1) ticks, and then `gate[c]` returns to 1.
- R5: Control register bit 0 enables the on-timer and bit 1 enables the off-timer. A phase whose timer is disabled lasts indefinitely, so with the on-timer disabled the gate stays on continuously.
- R6: The on→off event of channel c sets status bit 2c, and the off→on event sets status bit 2c+1. A status bit is set only if the same bit of the interrupt-enable register (address 4·NCH) is 1.
- R7: Writing the status register (address 4·NCH+1) clears every bit that is written as 1 and leaves the bits written as 0 unchanged. If a clear and a new event fall in the same cycle, the bit is set.
- R8: `irq` is 1 exactly when at least one status bit is 1.
- R9: A low `osc_en[c]` reloads the channel's counter. When the enable returns, the channel serves a complete on interval.
- R10: Channel c's registers sit at 4c (on-duration), 4c+1 (off-duration) and 4c+2 (control, 2 bits). Each register reads back what was last written into its implemented bits. Unimplemented bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data for `rd_addr` (combinational) |
| osc_en | input | NCH | Oscillator enable, one bit per channel |
| tick | input | 1 | Sample-rate tick that advances the timers |
| gate | output | NCH | Gate to each channel's oscillator |
| irq | output | 1 | Combined interrupt line |

## Verification
A wrong phase or a wrong count in a channel first shows on that channel's gate, at the tick where the interval should have ended, so it appears within one interval of the fault. A wrong pending flag shows on `irq` in the same cycle, and on the status readback whenever the read address points at the status register. The bench keeps its own model of the phase, count and status of every channel. It compares the gates, `irq` and the read data on every clock, so a divergence is reported in the cycle where it first becomes visible. The stimulus covers durations of 0, 1 and 64000, ticks that are spread out, mid-phase drops of the enable, masked events, and clears that fall in the same cycle as a new event.

// File: rtl/cadence_pkg.sv
package cadence_pkg;

   typedef enum logic {
      PH_ON  = 1'b0,
      PH_OFF = 1'b1
   } phase_e;

   localparam int REG_STRIDE   = 4;
   localparam int OFS_ON_DUR   = 0;
   localparam int OFS_OFF_DUR  = 1;
   localparam int OFS_CTRL     = 2;
   localparam int CTRL_W       = 2;
   localparam int CTRL_ON_BIT  = 0;
   localparam int CTRL_OFF_BIT = 1;

   // first address after the per-channel banks: interrupt enable, then status
   function automatic int glob_base(int nch);
      return nch * REG_STRIDE;
   endfunction

endpackage

// File: rtl/cadence_phase_timer.sv
module cadence_phase_timer
   import cadence_pkg::*;
#(
   parameter int DUR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             on_tmr_en,
   input  logic             off_tmr_en,
   input  logic [DUR_W-1:0] on_dur,
   input  logic [DUR_W-1:0] off_dur,
   output logic             gate,
   output logic             on_end,
   output logic             off_end
);

   phase_e           phase_q;
   logic [DUR_W-1:0] cnt_q;
   logic [DUR_W:0]   cnt_inc;
   logic [DUR_W-1:0] cur_dur;
   logic             cur_tmr_en;
   logic             expire;
   logic             step;

   always_comb begin
      cur_tmr_en = (phase_q == PH_ON) ? on_tmr_en : off_tmr_en;
      cur_dur    = (phase_q == PH_ON) ? on_dur : off_dur;
      cnt_inc    = {1'b0, cnt_q} + 1'b1;
      expire     = (cnt_inc >= {1'b0, cur_dur});
      step       = en && tick && cur_tmr_en;
   end

   assign on_end  = step && expire && (phase_q == PH_ON);
   assign off_end = step && expire && (phase_q == PH_OFF);
   assign gate    = en && (phase_q == PH_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_ON;
         cnt_q   <= '0;
      end else if (!en) begin
         phase_q <= PH_ON;
         cnt_q   <= '0;
      end else if (step) begin
         if (expire) begin
            phase_q <= (phase_q == PH_ON) ? PH_OFF : PH_ON;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_inc[DUR_W-1:0];
         end
      end
   end

   // R9: a low enable leaves the channel reloaded in the on phase
   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase_q == PH_ON && cnt_q == '0));

   // R2: a rising enable opens the gate at once
   p_start_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> gate);

   // R3: without a tick, nothing moves
   p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> ($stable(phase_q) && $stable(cnt_q)));

   // R5: a disabled timer holds its phase
   p_hold_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase_q == PH_ON && !on_tmr_en) |=> (phase_q == PH_ON));
   p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase_q == PH_OFF && !off_tmr_en) |=> (phase_q == PH_OFF));

endmodule

// File: rtl/cadence_irq.sv
module cadence_irq #(
   parameter int NEV = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] evt,
   input  logic [NEV-1:0] irq_en,
   input  logic [NEV-1:0] clr,
   output logic [NEV-1:0] status,
   output logic           irq
);

   logic [NEV-1:0] set_v;

   assign set_v = evt & irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | set_v;
   end

   assign irq = |status;

   for (genvar i = 0; i < NEV; i++) begin : g_chk
      // R6: a masked or absent event never raises a flag
      p_set_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!status[i] && !(evt[i] && irq_en[i])) |=> !status[i]);
      // R7: a clear with no new event drops the flag
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !(evt[i] && irq_en[i])) |=> !status[i]);
      // R7: a new event wins over a clear in the same cycle
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && irq_en[i]) |=> status[i]);
   end

   // R8: the line stays up until something is cleared
   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && clr == '0) |=> irq);
   // R8: the line stays down until an unmasked event occurs
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && set_v == '0) |=> !irq);

endmodule

// File: rtl/cadence_regs.sv
module cadence_regs
   import cadence_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int DUR_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int NEV    = 2 * NCH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [NEV-1:0]             status,
   output logic [NCH-1:0][DUR_W-1:0]  on_dur,
   output logic [NCH-1:0][DUR_W-1:0]  off_dur,
   output logic [NCH-1:0]             on_tmr_en,
   output logic [NCH-1:0]             off_tmr_en,
   output logic [NEV-1:0]             irq_en,
   output logic [NEV-1:0]             clr_mask
);

   localparam int IE_ADDR = glob_base(NCH);
   localparam int ST_ADDR = IE_ADDR + 1;

   logic [NCH-1:0][CTRL_W-1:0] ctrl_q;

   function automatic logic [ADDR_W-1:0] addr_of(int ch, int ofs);
      return ADDR_W'(ch * REG_STRIDE + ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_dur  <= '0;
         off_dur <= '0;
         ctrl_q  <= '0;
         irq_en  <= '0;
      end else if (wr_en) begin
         for (int c = 0; c < NCH; c++) begin
            if (wr_addr == addr_of(c, OFS_ON_DUR))  on_dur[c]  <= wr_data[DUR_W-1:0];
            if (wr_addr == addr_of(c, OFS_OFF_DUR)) off_dur[c] <= wr_data[DUR_W-1:0];
            if (wr_addr == addr_of(c, OFS_CTRL))    ctrl_q[c]  <= wr_data[CTRL_W-1:0];
         end
         if (wr_addr == ADDR_W'(IE_ADDR)) irq_en <= wr_data[NEV-1:0];
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ctrl
      assign on_tmr_en[c]  = ctrl_q[c][CTRL_ON_BIT];
      assign off_tmr_en[c] = ctrl_q[c][CTRL_OFF_BIT];
   end

   assign clr_mask = (wr_en && wr_addr == ADDR_W'(ST_ADDR)) ? wr_data[NEV-1:0] : '0;

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr == addr_of(c, OFS_ON_DUR))  rd_data = DATA_W'(on_dur[c]);
         if (rd_addr == addr_of(c, OFS_OFF_DUR)) rd_data = DATA_W'(off_dur[c]);
         if (rd_addr == addr_of(c, OFS_CTRL))    rd_data = DATA_W'(ctrl_q[c]);
      end
      if (rd_addr == ADDR_W'(IE_ADDR)) rd_data = DATA_W'(irq_en);
      if (rd_addr == ADDR_W'(ST_ADDR)) rd_data = DATA_W'(status);
   end

endmodule

// File: rtl/cadence_gate_ctrl.sv
module cadence_gate_ctrl
   import cadence_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int DUR_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NCH-1:0]    osc_en,
   input  logic              tick,
   output logic [NCH-1:0]    gate,
   output logic              irq
);

   localparam int NEV       = 2 * NCH;
   localparam int MIN_ADDRW = $clog2(glob_base(NCH) + 2);

   // elaboration-time parameter checks
   if (NCH < 1)               begin : g_bad_nch  $error("NCH must be at least 1");         end
   if (DUR_W < 2)             begin : g_bad_dur  $error("DUR_W must be at least 2");       end
   if (DATA_W < DUR_W)        begin : g_bad_dw   $error("DATA_W must cover DUR_W");        end
   if (DATA_W < NEV)          begin : g_bad_ev   $error("DATA_W must cover all events");   end
   if (ADDR_W < MIN_ADDRW)    begin : g_bad_aw   $error("ADDR_W too small for the map");   end

   logic [NCH-1:0][DUR_W-1:0] on_dur;
   logic [NCH-1:0][DUR_W-1:0] off_dur;
   logic [NCH-1:0]            on_tmr_en;
   logic [NCH-1:0]            off_tmr_en;
   logic [NCH-1:0]            on_end;
   logic [NCH-1:0]            off_end;
   logic [NEV-1:0]            evt;
   logic [NEV-1:0]            irq_en;
   logic [NEV-1:0]            clr_mask;
   logic [NEV-1:0]            status;

   cadence_regs #(
      .NCH(NCH), .DUR_W(DUR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NEV(NEV)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .status(status),
      .on_dur(on_dur), .off_dur(off_dur),
      .on_tmr_en(on_tmr_en), .off_tmr_en(off_tmr_en),
      .irq_en(irq_en), .clr_mask(clr_mask)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cadence_phase_timer #(.DUR_W(DUR_W)) u_tmr (
         .clk(clk), .rst_n(rst_n),
         .en(osc_en[c]), .tick(tick),
         .on_tmr_en(on_tmr_en[c]), .off_tmr_en(off_tmr_en[c]),
         .on_dur(on_dur[c]), .off_dur(off_dur[c]),
         .gate(gate[c]), .on_end(on_end[c]), .off_end(off_end[c])
      );
      assign evt[2*c]   = on_end[c];
      assign evt[2*c+1] = off_end[c];
   end

   cadence_irq #(.NEV(NEV)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .evt(evt), .irq_en(irq_en), .clr(clr_mask),
      .status(status), .irq(irq)
   );

   // R1: nothing is gated or pending in the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq));

endmodule

// File: tb/sim_cadence_gate_ctrl.sv
module sim_cadence_gate_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCH    = 2;
   localparam int DUR_W  = 16;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 4;
   localparam int IE_A   = 8;
   localparam int ST_A   = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic [NCH-1:0]    osc_en = '0;
   logic              tick = 1'b0;
   logic [NCH-1:0]    gate;
   logic              irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   cadence_gate_ctrl #(.NCH(NCH), .DUR_W(DUR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .osc_en(osc_en), .tick(tick),
      .gate(gate), .irq(irq)
   );

   // behavioural reference state
   int m_ph[NCH];    // 0 = on, 1 = off
   int m_cnt[NCH];
   int m_on[NCH];
   int m_off[NCH];
   int m_ctrl[NCH];
   int m_ie;
   int m_st;

   int    n_cmp = 0;
   int    n_bad = 0;
   string req = "R1";
   int    tick_div = 1;
   int    tick_ph = 0;
   bit    done = 0;

   function automatic int model_read(int a);
      if (a < NCH * 4) begin
         case (a % 4)
            0: return m_on[a/4];
            1: return m_off[a/4];
            2: return m_ctrl[a/4];
            default: return 0;
         endcase
      end
      if (a == IE_A) return m_ie;
      if (a == ST_A) return m_st;
      return 0;
   endfunction

   task automatic chk(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int ev;
      int clr;
      ev = 0;
      for (int c = 0; c < NCH; c++) begin
         if (!osc_en[c]) begin
            m_ph[c] = 0;
            m_cnt[c] = 0;
         end else if (tick) begin
            int ten;
            int dur;
            ten = (m_ph[c] == 0) ? (m_ctrl[c] & 1) : ((m_ctrl[c] >> 1) & 1);
            dur = (m_ph[c] == 0) ? m_on[c] : m_off[c];
            if (ten != 0) begin
               if (m_cnt[c] + 1 >= dur) begin
                  ev = ev | (1 << (2*c + m_ph[c]));
                  m_ph[c] = 1 - m_ph[c];
                  m_cnt[c] = 0;
               end else begin
                  m_cnt[c] = m_cnt[c] + 1;
               end
            end
         end
      end
      clr = (wr_en && int'(wr_addr) == ST_A) ? (int'(wr_data) & 15) : 0;
      m_st = (m_st & ~clr) | (ev & m_ie);
      if (wr_en) begin
         int a;
         a = int'(wr_addr);
         if (a < NCH * 4) begin
            case (a % 4)
               0: m_on[a/4]   = int'(wr_data);
               1: m_off[a/4]  = int'(wr_data);
               2: m_ctrl[a/4] = int'(wr_data) & 3;
               default: ;
            endcase
         end
         if (a == IE_A) m_ie = int'(wr_data) & 15;
      end
   endtask

   // one clock: drive tick, compare outputs, advance model at the edge
   task automatic cyc();
      tick = (tick_div <= 1) ? 1'b1 : ((tick_ph % tick_div) == 0);
      tick_ph++;
      #1;
      for (int c = 0; c < NCH; c++)
         chk($sformatf("gate[%0d]", c), int'(gate[c]), (osc_en[c] && m_ph[c] == 0) ? 1 : 0);
      chk("R8 irq", int'(irq), (m_st != 0) ? 1 : 0);
      chk($sformatf("rd_data@%0d", rd_addr), int'(rd_data), model_read(int'(rd_addr)));
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1;
      wr_addr = ADDR_W'(a);
      wr_data = DATA_W'(d);
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_ph[c] = 0; m_cnt[c] = 0; m_on[c] = 0; m_off[c] = 0; m_ctrl[c] = 0;
      end
      m_ie = 0;
      m_st = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state at the ports and in the register file
      req = "R1";
      for (int a = 0; a < 10; a++) begin
         rd_addr = ADDR_W'(a);
         run(1);
      end

      // R10: register map and readback, including truncated control bits
      req = "R10";
      wr(0, 5); wr(1, 3); wr(2, 16'hFFFF); wr(2, 3);
      wr(4, 2); wr(5, 0); wr(6, 1); wr(IE_A, 16'hFFFF);
      for (int a = 0; a < 16; a++) begin
         rd_addr = ADDR_W'(a);
         run(1);
      end
      rd_addr = ADDR_W'(ST_A);

      // R2: rising enable starts in the on phase
      req = "R2";
      osc_en = 2'b01;
      run(1);

      // R3 and R4: cadence with a tick every cycle, then every third cycle
      req = "R3";
      tick_div = 1;
      run(40);
      req = "R4";
      tick_div = 3;
      run(60);

      // R5: channel 1 has only its on-timer enabled and sticks in the off phase;
      // channel 0 then loses its on-timer and stays gated on
      req = "R5";
      tick_div = 1;
      osc_en = 2'b11;
      run(20);
      wr(2, 2);
      run(40);
      wr(6, 2);
      run(20);

      // R7: periodic clears interleaved with events, some in the same cycle
      req = "R7";
      wr(2, 3); wr(6, 3); wr(4, 3); wr(5, 2);
      for (int i = 0; i < 24; i++) begin
         run(4);
         wr(ST_A, (i % 2 == 0) ? 15 : 5);
      end
      for (int i = 0; i < 16; i++) wr(ST_A, 15);

      // R6: only the on-to-off events are unmasked
      req = "R6";
      wr(IE_A, 5);
      wr(ST_A, 15);
      run(40);
      wr(ST_A, 15);

      // R9: drop the enable mid-phase and bring it back
      req = "R9";
      wr(0, 10); wr(1, 10);
      run(4);
      osc_en = 2'b10;
      run(3);
      osc_en = 2'b11;
      run(30);

      // R3 boundary: zero and one tick durations
      req = "R3";
      wr(IE_A, 15);
      wr(0, 0); wr(1, 1);
      tick_div = 2;
      run(20);

      // R3 maximum: 8 s of 8 kHz ticks
      wr(0, 64000); wr(1, 2);
      osc_en = 2'b00;
      run(1);
      osc_en = 2'b01;
      tick_div = 1;
      run(64010);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule